// File: doc/BRIEF.md
# Static Memory Line Read Sequencer

The sequencer drives the strobes of an external asynchronous memory shared by several regions: an active-low select per region, a shared address bus, an active-low output enable and an active-low write enable. A request names a region, a base word address and a direction. The region's configuration word then sets the timing. That word carries a device class, a first-beat latency `FIRST`, a following-beat latency `NEXT` and a bus release delay `HOLDOFF`.

A read always fetches a line of `BEATS` words (8 by default) at consecutive addresses. Each word arrives on `rdata_o` with a one-cycle `rvalid_o` strobe. Whether a beat uses `FIRST` or `NEXT` depends on the device class and the beat index. A write moves one word. `done_o` marks the end of every accepted request.

Before the sequencer drives a region other than the last one accepted, it waits `HOLDOFF` clocks of the previous region. This gives the previous device time to float the data bus.

Top module: `smc_read_seq`

## Requirements
- R1: After reset, every select, `noe_o` and `nwe_o` are high, and `busy_o`, `done_o`, `err_o` and `rvalid_o` are low.
- R2: The configuration word of region k sits at `cfg_i[k*14 +: 14]`. Its fields are: bits [2:0] device class, [6:3] `FIRST`, [10:7] `NEXT`, [13:11] `HOLDOFF`. Device class 0 is a single-word ROM, 1 is SRAM, 2 is a ROM that bursts in groups of four, and 3 is a ROM that bursts eight. A start naming class 4 to 7 raises `err_o` for one cycle, in the cycle after the start. It drives no select and raises no `done_o`.
- R3: A read drives the selected region's select low and `noe_o` low without a break through all `BEATS` beats. `bus_addr_o` is the base address plus the beat index.
- R4: For classes 0 and 1, every read beat lasts `FIRST`+1 clocks.
- R5: For class 2, a beat whose index is a multiple of 4 lasts `FIRST`+1 clocks. Every other beat lasts `NEXT`+1 clocks.
- R6: For class 3, beat 0 lasts `FIRST`+1 clocks and every later beat lasts `NEXT`+1 clocks.
- R7: In the cycle after the last clock of each read beat, `rvalid_o` is high. `rdata_o` then holds the value `bus_din_i` had during that last clock.
- R8: A write to class 0, 2 or 3 is one beat. During that beat the select and `nwe_o` are low for `FIRST`+1 clocks, `noe_o` stays high and `bus_dout_o` carries the write data.
- R9: A write to class 1 holds the select low for `NEXT`+2 clocks. `nwe_o` is low for the first `NEXT`+1 of them and high in the last.
- R10: `done_o` is high for exactly one cycle, the cycle after the last bus clock. In that cycle every select is high and `busy_o` is low.
- R11: If the previously accepted request went to the same region, or no request has been accepted since reset, the select falls in the cycle after the start. Otherwise it falls `HOLDOFF` clocks later, using the `HOLDOFF` of the previously accepted region.
- R12: A start while `busy_o` is high is ignored.
- R13: At most one select is low at a time, and `noe_o` and `nwe_o` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | memory clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | request strobe, taken when idle |
| write_i | input | 1 | 1 = write one word, 0 = read a line |
| region_i | input | 2 | target region |
| addr_i | input | 16 | base word address |
| wdata_i | input | 16 | write data |
| cfg_i | input | 56 | configuration words, 14 bits per region |
| bus_din_i | input | 16 | data from the memory bus |
| ncs_o | output | 4 | per-region select, active low |
| noe_o | output | 1 | output enable, active low |
| nwe_o | output | 1 | write enable, active low |
| bus_addr_o | output | 16 | memory address |
| bus_dout_o | output | 16 | data to the memory bus |
| rdata_o | output | 16 | captured read word |
| rvalid_o | output | 1 | read word strobe |
| done_o | output | 1 | request complete |
| err_o | output | 1 | request rejected (bad class) |
| busy_o | output | 1 | request in progress |

## Verification
Some properties can be checked on every cycle: selects stay exclusive, the two enables never overlap, `noe_o` is low only while a select is low, a read word appears only after a cycle with `noe_o` low, and `done_o` and `err_o` are single idle-bus pulses. Other behaviour only the bench scenarios can show. That covers per-beat durations for each device class, where the first-latency beats fall in a line, the address sequence, the captured data, the SRAM write-enable release, and the holdoff gap that appears on a change of region and vanishes on a repeat. The bench sweeps every class code against several latency pairs, in both directions, across regions with different holdoffs.

// File: rtl/smc_pkg.sv
package smc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GAP,
        ST_BUS
    } st_e;

    localparam logic [2:0] DT_SRAM   = 3'd1;
    localparam logic [2:0] DT_BURST4 = 3'd2;
    localparam logic [2:0] DT_BURST8 = 3'd3;
endpackage

// File: rtl/smc_cfg_sel.sv
module smc_cfg_sel #(
    parameter int NREG = 4,
    parameter int LW   = 4,
    parameter int RW   = 3,
    localparam int RGW  = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int CFGW = 3 + 2 * LW + RW
) (
    input  logic [NREG*CFGW-1:0] cfg_i,
    input  logic [RGW-1:0]       region_i,
    output logic [2:0]           dt_o,
    output logic [LW-1:0]        first_o,
    output logic [LW-1:0]        next_o,
    output logic [RW-1:0]        hold_o,
    output logic                 ok_o
);
    import smc_pkg::*;

    logic [CFGW-1:0] words [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_unpack
        assign words[i] = cfg_i[i*CFGW +: CFGW];
    end

    logic [CFGW-1:0] pick;
    assign pick    = words[region_i];
    assign dt_o    = pick[2:0];
    assign first_o = pick[3 +: LW];
    assign next_o  = pick[3+LW +: LW];
    assign hold_o  = pick[3+2*LW +: RW];
    assign ok_o    = (pick[2:0] <= DT_BURST8);
endmodule

// File: rtl/smc_beat_len.sv
module smc_beat_len #(
    parameter int LW = 4,
    parameter int BW = 3
) (
    input  logic [2:0]    dt_i,
    input  logic [LW-1:0] first_i,
    input  logic [LW-1:0] next_i,
    input  logic [BW-1:0] beat_i,
    input  logic          wr_i,
    output logic [LW:0]   last_o
);
    import smc_pkg::*;

    logic [LW:0]   lat_first;
    logic [LW:0]   lat_next;
    logic [BW-1:0] quad_mask;

    assign lat_first = {1'b0, first_i};
    assign lat_next  = {1'b0, next_i};
    assign quad_mask = BW'(3);

    always_comb begin
        if (wr_i) begin
            last_o = (dt_i == DT_SRAM) ? lat_next + 1'b1 : lat_first;
        end else begin
            unique case (dt_i)
                DT_BURST4: last_o = ((beat_i & quad_mask) == '0) ? lat_first : lat_next;
                DT_BURST8: last_o = (beat_i == '0) ? lat_first : lat_next;
                default:   last_o = lat_first;
            endcase
        end
    end
endmodule

// File: rtl/smc_read_seq.sv
module smc_read_seq #(
    parameter int NREG  = 4,
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int LW    = 4,
    parameter int RW    = 3,
    parameter int BEATS = 8,
    localparam int RGW  = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int CFGW = 3 + 2 * LW + RW
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic                 write_i,
    input  logic [RGW-1:0]       region_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [DW-1:0]        wdata_i,
    input  logic [NREG*CFGW-1:0] cfg_i,
    input  logic [DW-1:0]        bus_din_i,
    output logic [NREG-1:0]      ncs_o,
    output logic                 noe_o,
    output logic                 nwe_o,
    output logic [AW-1:0]        bus_addr_o,
    output logic [DW-1:0]        bus_dout_o,
    output logic [DW-1:0]        rdata_o,
    output logic                 rvalid_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic                 busy_o
);
    import smc_pkg::*;

    localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int CW = (LW + 1 > RW) ? LW + 1 : RW;

    typedef struct packed {
        st_e             st;
        logic [CW-1:0]   cnt;
        logic [BW-1:0]   beat;
        logic            wr;
        logic [2:0]      dt;
        logic [LW-1:0]   first;
        logic [LW-1:0]   next;
        logic [RGW-1:0]  reg_cur;
        logic            have_last;
        logic [RGW-1:0]  last_reg;
        logic [RW-1:0]   last_hold;
        logic [NREG-1:0] ncs;
        logic            noe;
        logic            nwe;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   dout;
        logic [DW-1:0]   rdata;
        logic            rvalid;
        logic            done;
        logic            err;
        logic            busy;
    } regs_t;

    regs_t q, d;

    logic [2:0]    sel_dt;
    logic [LW-1:0] sel_first;
    logic [LW-1:0] sel_next;
    logic [RW-1:0] sel_hold;
    logic          sel_ok;
    logic [LW:0]   blen;
    logic [CW-1:0] beat_last;
    logic          launch;

    smc_cfg_sel #(.NREG(NREG), .LW(LW), .RW(RW)) u_cfg (
        .cfg_i    (cfg_i),
        .region_i (region_i),
        .dt_o     (sel_dt),
        .first_o  (sel_first),
        .next_o   (sel_next),
        .hold_o   (sel_hold),
        .ok_o     (sel_ok)
    );

    smc_beat_len #(.LW(LW), .BW(BW)) u_len (
        .dt_i    (q.dt),
        .first_i (q.first),
        .next_i  (q.next),
        .beat_i  (q.beat),
        .wr_i    (q.wr),
        .last_o  (blen)
    );

    assign beat_last = CW'(blen);

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.err    = 1'b0;
        d.rvalid = 1'b0;
        launch   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (!sel_ok) begin
                        d.err = 1'b1;
                    end else begin
                        d.wr        = write_i;
                        d.dt        = sel_dt;
                        d.first     = sel_first;
                        d.next      = sel_next;
                        d.reg_cur   = region_i;
                        d.addr      = addr_i;
                        d.dout      = wdata_i;
                        d.busy      = 1'b1;
                        d.have_last = 1'b1;
                        d.last_reg  = region_i;
                        d.last_hold = sel_hold;
                        if (q.have_last && q.last_reg != region_i && q.last_hold != '0) begin
                            d.st  = ST_GAP;
                            d.cnt = CW'(q.last_hold) - 1'b1;
                        end else begin
                            launch = 1'b1;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (q.cnt == '0) launch = 1'b1;
                else             d.cnt  = q.cnt - 1'b1;
            end
            ST_BUS: begin
                if (q.cnt == beat_last) begin
                    if (!q.wr) begin
                        d.rdata  = bus_din_i;
                        d.rvalid = 1'b1;
                    end
                    if (q.wr || q.beat == BW'(BEATS - 1)) begin
                        d.st   = ST_IDLE;
                        d.ncs  = '1;
                        d.noe  = 1'b1;
                        d.nwe  = 1'b1;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.beat = q.beat + 1'b1;
                        d.cnt  = '0;
                        d.addr = q.addr + 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.wr && q.dt == DT_SRAM && (q.cnt + 1'b1) == beat_last) d.nwe = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (launch) begin
            d.st             = ST_BUS;
            d.cnt            = '0;
            d.beat           = '0;
            d.ncs            = '1;
            d.ncs[d.reg_cur] = 1'b0;
            d.noe            = d.wr;
            d.nwe            = !d.wr;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q     <= '0;
            q.ncs <= '1;
            q.noe <= 1'b1;
            q.nwe <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ncs_o      = q.ncs;
    assign noe_o      = q.noe;
    assign nwe_o      = q.nwe;
    assign bus_addr_o = q.addr;
    assign bus_dout_o = q.dout;
    assign rdata_o    = q.rdata;
    assign rvalid_o   = q.rvalid;
    assign done_o     = q.done;
    assign err_o      = q.err;
    assign busy_o     = q.busy;
endmodule

// File: rtl/smc_read_seq_chk.sv
module smc_read_seq_chk #(
    parameter int NREG = 4
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [NREG-1:0] ncs_o,
    input logic            noe_o,
    input logic            nwe_o,
    input logic            rvalid_o,
    input logic            done_o,
    input logic            err_o,
    input logic            busy_o
);
    a_r13_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(~ncs_o) <= 1);

    a_r13_no_enable_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(!noe_o && !nwe_o));

    a_r3_oe_under_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !noe_o |-> (ncs_o != '1));

    a_r7_word_after_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rvalid_o |-> $past(!noe_o));

    a_r10_done_bus_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (ncs_o == '1 && !busy_o));

    a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r2_reject_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (ncs_o == '1 && !done_o && !busy_o));
endmodule

bind smc_read_seq smc_read_seq_chk #(.NREG(NREG)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ncs_o    (ncs_o),
    .noe_o    (noe_o),
    .nwe_o    (nwe_o),
    .rvalid_o (rvalid_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .busy_o   (busy_o)
);

// File: tb/smc_read_seq_test.sv
module smc_read_seq_test;
    localparam int NREG = 4;
    localparam int LINE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  region = '0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [55:0] cfg;
    logic [15:0] bus_din;
    logic [3:0]  ncs;
    logic        noe, nwe, rvalid, done, err, busy;
    logic [15:0] bus_addr, bus_dout, rdata;

    logic [2:0] dt_a   [NREG];
    logic [3:0] first_a[NREG];
    logic [3:0] next_a [NREG];
    logic [2:0] hold_a [NREG];

    int total = 0;
    int bad = 0;
    bit prev_valid = 0;
    int prev_reg = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NREG; i++)
            cfg[i*14 +: 14] = {hold_a[i], next_a[i], first_a[i], dt_a[i]};
    end

    assign bus_din = bus_addr ^ 16'h5A3C;

    smc_read_seq uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(wr),
        .region_i(region), .addr_i(addr), .wdata_i(wdata), .cfg_i(cfg),
        .bus_din_i(bus_din), .ncs_o(ncs), .noe_o(noe), .nwe_o(nwe),
        .bus_addr_o(bus_addr), .bus_dout_o(bus_dout), .rdata_o(rdata),
        .rvalid_o(rvalid), .done_o(done), .err_o(err), .busy_o(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int lenb(int t, int b, int rf, int rn);
        if (t == 2) return (b % 4 == 0) ? rf + 1 : rn + 1;
        if (t == 3) return (b == 0) ? rf + 1 : rn + 1;
        return rf + 1;
    endfunction

    function automatic void locate(int t, int rf, int rn, int j, output int b, output int off, output int len);
        int acc = 0;
        b = 0;
        len = lenb(t, 0, rf, rn);
        while (j >= acc + len) begin
            acc += len;
            b++;
            len = lenb(t, b, rf, rn);
        end
        off = j - acc;
    endfunction

    task automatic run(input int rg, input bit w, input logic [15:0] base, input logic [15:0] wd, input bit inject);
        int t  = dt_a[rg];
        int rf = first_a[rg];
        int rn = next_a[rg];
        int g;
        int tt;
        string sreq;
        g = (prev_valid && prev_reg != rg) ? hold_a[prev_reg] : 0;
        if (w) tt = (t == 1) ? rn + 2 : rf + 1;
        else begin
            tt = 0;
            for (int b = 0; b < LINE; b++) tt += lenb(t, b, rf, rn);
        end
        sreq = w ? ((t == 1) ? "R9" : "R8") : ((t == 2) ? "R5" : (t == 3) ? "R6" : "R4");
        @(negedge clk);
        start = 1'b1; wr = w; region = 2'(rg); addr = base; wdata = wd;
        @(negedge clk);
        start = 1'b0;
        if (t >= 4) begin
            chk(err == 1'b1, "R2", err, 1);
            for (int k = 1; k <= 3; k++) begin
                chk(ncs == 4'hF && !done && !busy, "R2", {ncs, done, busy}, {4'hF, 2'b00});
                @(negedge clk);
            end
            return;
        end
        for (int k = 1; k <= g + tt + 1; k++) begin
            bit inwin = (k >= g + 1) && (k <= g + tt);
            bit pwin  = (k - 1 >= g + 1) && (k - 1 <= g + tt);
            logic [3:0] exp_ncs = inwin ? ~(4'b1 << rg) : 4'hF;
            logic exp_noe = 1'b1;
            logic exp_nwe = 1'b1;
            logic [15:0] exp_addr = base;
            int b, off, len;
            chk(ncs == exp_ncs, (k <= g + 1) ? "R11" : (w ? sreq : "R3"), ncs, exp_ncs);
            chk($countones(~ncs) <= 1 && !(!noe && !nwe), "R13", {ncs, noe, nwe}, 0);
            if (inwin) begin
                if (w) begin
                    exp_nwe = (t == 1 && k - g - 1 == tt - 1) ? 1'b1 : 1'b0;
                    chk(bus_dout == wd, sreq, bus_dout, wd);
                end else begin
                    locate(t, rf, rn, k - g - 1, b, off, len);
                    exp_noe = 1'b0;
                    exp_addr = base + 16'(b);
                end
                chk(bus_addr == exp_addr, "R3", bus_addr, exp_addr);
            end
            chk(noe == exp_noe && nwe == exp_nwe, sreq, {noe, nwe}, {exp_noe, exp_nwe});
            if (!w && pwin) begin
                locate(t, rf, rn, k - g - 2, b, off, len);
                if (off == len - 1) begin
                    logic [15:0] exp_d = (base + 16'(b)) ^ 16'h5A3C;
                    chk(rvalid == 1'b1 && rdata == exp_d, "R7", {rvalid, rdata}, {1'b1, exp_d});
                end else chk(rvalid == 1'b0, "R7", rvalid, 0);
            end else chk(rvalid == 1'b0, "R7", rvalid, 0);
            chk(done == (k == g + tt + 1) && busy == (k <= g + tt), "R10", {done, busy}, {k == g + tt + 1, k <= g + tt});
            if (inject && k == 2) begin
                start = 1'b1; wr = 1'b0; region = 2'((rg + 1) % NREG); addr = 16'h7777;
            end else if (inject && k == 3) start = 1'b0;
            @(negedge clk);
        end
        prev_valid = 1;
        prev_reg = rg;
        if (inject) begin
            for (int k = 0; k < 3; k++) begin
                chk(ncs == 4'hF && !busy && !done, "R12", {ncs, busy, done}, {4'hF, 2'b00});
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int iter = 0;
        int rfs[3] = '{0, 2, 3};
        int rns[3] = '{0, 1, 3};
        hold_a[0] = 3'd0; hold_a[1] = 3'd2; hold_a[2] = 3'd5; hold_a[3] = 3'd7;
        for (int i = 0; i < NREG; i++) begin
            dt_a[i] = 3'd0; first_a[i] = 4'd0; next_a[i] = 4'd0;
        end
        repeat (3) @(negedge clk);
        chk(ncs == 4'hF && noe && nwe, "R1", {ncs, noe, nwe}, {4'hF, 2'b11});
        chk(!busy && !done && !err && !rvalid, "R1", {busy, done, err, rvalid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ncs == 4'hF && noe && nwe && !busy, "R1", {ncs, noe, nwe, busy}, {4'hF, 3'b110});
        for (int t = 0; t < 8; t++)
            for (int a = 0; a < 3; a++)
                for (int n = 0; n < 3; n++)
                    for (int w = 0; w < 2; w++) begin
                        int rg = (iter / 2) % NREG;
                        dt_a[rg] = 3'(t); first_a[rg] = 4'(rfs[a]); next_a[rg] = 4'(rns[n]);
                        run(rg, w[0], 16'(iter * 16 + 3), 16'(16'hC000 + iter), 1'b0);
                        iter++;
                    end
        dt_a[1] = 3'd3; first_a[1] = 4'd3; next_a[1] = 4'd1;
        run(1, 1'b0, 16'h0100, 16'h0, 1'b1);
        dt_a[2] = 3'd2; first_a[2] = 4'd15; next_a[2] = 4'd15;
        run(2, 1'b0, 16'hFFFC, 16'h0, 1'b0);
        run(2, 1'b1, 16'h0042, 16'hBEEF, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule